// File: doc/BRIEF.md
# Floating-Point Exception Status Commit Unit

This unit is the last stage of a scalar fused multiply-subtract whose result has been rounded to single precision and widened back to double format. It takes the raw exception indicators produced by the arithmetic datapath and the two forms of the rounded result. On the same clock edge it does three things: it folds the indicators into a floating-point status register, it decides whether the destination register is written, and it raises a trap when the vector-scalar facility is switched off. The arithmetic itself is outside the unit.

An operation is presented for one cycle with `op_valid` high. All decisions are registered on that edge. The write strobe, the destination halves, the trap request and the new status appear in the following cycle. Indicators are only looked at while `op_valid` is high, so nothing carries over from one operation to the next except the sticky bits of the status register.

Status register layout (`stat_o`, 14 bits):
- bit 0: exception summary
- bit 1: signalling-NaN invalid
- bit 2: infinity-times-zero invalid
- bit 3: infinity-minus-infinity invalid
- bit 4: overflow
- bit 5: underflow
- bit 6: inexact
- bit 7: fraction rounded
- bit 8: fraction inexact
- bits 13:9: result class

Top module: `fpx_commit`

## Requirements
- R1: While reset is held and after it is released, `stat_o` is all zeros and `wr_en_o` and `trap_o` are 0 until the first operation is accepted.
- R2: An operation with `fac_en`=0 produces `trap_o`=1 in the next cycle, with `wr_en_o`=0 and `stat_o` unchanged.
- R3: In an operation with `fac_en`=1, each indicator that is 1 sets its own sticky bit: snan to bit 1, imz to bit 2, isi to bit 3, ovf to bit 4, unf to bit 5, inx to bit 6. Sticky bits are never cleared except by reset. A cycle with `op_valid`=0 changes nothing, whatever the indicator inputs carry.
- R4: The summary bit (bit 0) is set when at least one sticky bit goes from 0 to 1 in an operation. If no sticky bit rises, the summary keeps its value. The summary is only cleared by reset.
- R5: An enabled-invalid condition exists exactly when `inv_en`=1 and at least one of snan, imz or isi is 1.
- R6: With no enabled-invalid condition, the next cycle has `wr_en_o`=1, `wr_hi_o` equal to `res64_i`, and `wr_lo_o` all zeros.
- R7: With no enabled-invalid condition, bit 7 takes `rinc_i`, bit 8 takes `inx_i`, and bits 13:9 take the class of `res32_i`.
- R8: With an enabled-invalid condition, `wr_en_o` stays 0, bits 7 and 8 are cleared, bits 13:9 keep their old value, and the sticky bits and summary are still updated.
- R9: The class codes (bits 13:9) are:

  | Class of `res32_i` | Code |
  |---|---|
  | any NaN | 10001 |
  | +infinity | 00101 |
  | -infinity | 01001 |
  | +normal | 00100 |
  | -normal | 01000 |
  | +denormal | 10100 |
  | -denormal | 11000 |
  | +zero | 00010 |
  | -zero | 10010 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One operation is presented this cycle |
| fac_en | input | 1 | Vector-scalar facility enabled |
| inv_en | input | 1 | Invalid-operation trap enable |
| snan_i | input | 1 | Signalling-NaN invalid indicator |
| imz_i | input | 1 | Infinity-times-zero invalid indicator |
| isi_i | input | 1 | Infinity-minus-infinity invalid indicator |
| ovf_i | input | 1 | Overflow indicator |
| unf_i | input | 1 | Underflow indicator |
| inx_i | input | 1 | Inexact indicator |
| rinc_i | input | 1 | Rounding incremented the fraction |
| res32_i | input | 32 | Rounded result in binary32 form |
| res64_i | input | 64 | Rounded result in binary64 form |
| wr_en_o | output | 1 | Destination write strobe |
| wr_hi_o | output | 64 | Upper doubleword to write |
| wr_lo_o | output | 64 | Lower doubleword to write |
| stat_o | output | 14 | Floating-point status register |
| trap_o | output | 1 | Facility-unavailable trap request |

## Verification
The bound checker watches the following on every cycle:
- the trap-with-no-effect response to a disabled facility;
- suppression of the write strobe, together with clearing of the two fraction bits, under an enabled-invalid condition;
- the written upper half matching the presented binary64 result, with the lower half zero;
- sticky bits and the summary never falling;
- idle cycles leaving everything alone.

The bench scenarios are the only place that shows the rest:
- the exact class code for each binary32 category;
- which indicator lands on which bit;
- the summary rising only on a fresh 0-to-1 transition;
- every combination of the three invalid indicators with `inv_en` both set and clear.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int STAT_W = 14;
  localparam int NSTK   = 6;
  localparam int CLS_W  = 5;

  localparam int SUM_B  = 0;
  localparam int STK_LO = 1;
  localparam int STK_HI = STK_LO + NSTK - 1;
  localparam int FR_B   = STK_HI + 1;
  localparam int FI_B   = FR_B + 1;
  localparam int CLS_LO = FI_B + 1;
  localparam int CLS_HI = CLS_LO + CLS_W - 1;

  typedef logic [CLS_W-1:0] cls_t;

  localparam cls_t CLS_QNAN  = 5'b10001;
  localparam cls_t CLS_PINF  = 5'b00101;
  localparam cls_t CLS_NINF  = 5'b01001;
  localparam cls_t CLS_PNORM = 5'b00100;
  localparam cls_t CLS_NNORM = 5'b01000;
  localparam cls_t CLS_PDEN  = 5'b10100;
  localparam cls_t CLS_NDEN  = 5'b11000;
  localparam cls_t CLS_PZERO = 5'b00010;
  localparam cls_t CLS_NZERO = 5'b10010;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int SW = 32,
  parameter int EW = 8
) (
  input  logic [SW-1:0] val_i,
  output cls_t          cls_o
);
  localparam int FW = SW - 1 - EW;

  logic          sgn;
  logic [EW-1:0] expo;
  logic [FW-1:0] frac;
  logic          exp_max, exp_zero, frac_zero;

  always_comb begin
    sgn       = val_i[SW-1];
    expo      = val_i[SW-2:FW];
    frac      = val_i[FW-1:0];
    exp_max   = &expo;
    exp_zero  = ~|expo;
    frac_zero = ~|frac;
    if (exp_max) begin
      if (!frac_zero) cls_o = CLS_QNAN;
      else            cls_o = sgn ? CLS_NINF : CLS_PINF;
    end else if (exp_zero) begin
      if (frac_zero)  cls_o = sgn ? CLS_NZERO : CLS_PZERO;
      else            cls_o = sgn ? CLS_NDEN : CLS_PDEN;
    end else begin
      cls_o = sgn ? CLS_NNORM : CLS_PNORM;
    end
  end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky #(
  parameter int N = 6
) (
  input  logic         cap_i,
  input  logic [N-1:0] raise_i,
  input  logic [N-1:0] old_i,
  output logic [N-1:0] nxt_o,
  output logic         fresh_o
);
  logic [N-1:0] rise;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign nxt_o[i] = old_i[i] | (cap_i & raise_i[i]);
    assign rise[i]  = cap_i & raise_i[i] & ~old_i[i];
  end

  assign fresh_o = |rise;
endmodule

// File: rtl/fpx_wb.sv
module fpx_wb #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] hi_i,
  output logic          wr_en_o,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o
);
  logic          en_d;
  logic [DW-1:0] hi_d, lo_d;

  always_comb begin
    en_d = load_i;
    hi_d = hi_o;
    lo_d = lo_o;
    if (load_i) begin
      hi_d = hi_i;
      lo_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
    end else begin
      wr_en_o <= en_d;
      hi_o    <= hi_d;
      lo_o    <= lo_d;
    end
  end
endmodule

// File: rtl/fpx_commit.sv
module fpx_commit
  import fpx_pkg::*;
#(
  parameter int DW = 64,
  parameter int SW = 32,
  parameter int EW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              fac_en,
  input  logic              inv_en,
  input  logic              snan_i,
  input  logic              imz_i,
  input  logic              isi_i,
  input  logic              ovf_i,
  input  logic              unf_i,
  input  logic              inx_i,
  input  logic              rinc_i,
  input  logic [SW-1:0]     res32_i,
  input  logic [DW-1:0]     res64_i,
  output logic              wr_en_o,
  output logic [DW-1:0]     wr_hi_o,
  output logic [DW-1:0]     wr_lo_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              trap_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // operation decode
  logic go, vx_any, vex, load;
  logic [NSTK-1:0] raise;

  always_comb begin
    go     = op_valid & fac_en;
    vx_any = snan_i | imz_i | isi_i;
    vex    = inv_en & vx_any;
    load   = go & ~vex;
    raise  = {inx_i, unf_i, ovf_i, isi_i, imz_i, snan_i};
  end

  cls_t cls_new;

  fpx_classify #(.SW(SW), .EW(EW)) u_cls (
    .val_i (res32_i),
    .cls_o (cls_new)
  );

  logic [NSTK-1:0] stk_nxt;
  logic            fresh;
  logic [STAT_W-1:0] stat_q, stat_d;

  fpx_sticky #(.N(NSTK)) u_stk (
    .cap_i   (go),
    .raise_i (raise),
    .old_i   (stat_q[STK_HI:STK_LO]),
    .nxt_o   (stk_nxt),
    .fresh_o (fresh)
  );

  // status next state
  always_comb begin
    stat_d = stat_q;
    if (go) begin
      stat_d[STK_HI:STK_LO] = stk_nxt;
      stat_d[SUM_B]         = stat_q[SUM_B] | fresh;
      if (vex) begin
        stat_d[FR_B] = 1'b0;
        stat_d[FI_B] = 1'b0;
      end else begin
        stat_d[FR_B]          = rinc_i;
        stat_d[FI_B]          = inx_i;
        stat_d[CLS_HI:CLS_LO] = cls_new;
      end
    end
  end

  logic trap_d;
  assign trap_d = op_valid & ~fac_en;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stat_q <= '0;
      trap_o <= 1'b0;
    end else begin
      stat_q <= stat_d;
      trap_o <= trap_d;
    end
  end

  assign stat_o = stat_q;

  fpx_wb #(.DW(DW)) u_wb (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load_i  (load),
    .hi_i    (res64_i),
    .wr_en_o (wr_en_o),
    .hi_o    (wr_hi_o),
    .lo_o    (wr_lo_o)
  );
endmodule

// File: rtl/fpx_commit_chk.sv
module fpx_commit_chk
  import fpx_pkg::*;
#(
  parameter int DW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              fac_en,
  input logic              inv_en,
  input logic              snan_i,
  input logic              imz_i,
  input logic              isi_i,
  input logic [DW-1:0]     res64_i,
  input logic              wr_en_o,
  input logic [DW-1:0]     wr_hi_o,
  input logic [DW-1:0]     wr_lo_o,
  input logic [STAT_W-1:0] stat_o,
  input logic              trap_o
);
  // R2
  disabled_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !fac_en |=> trap_o && !wr_en_o && $stable(stat_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(stat_o) && !wr_en_o && !trap_o);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_o[STK_HI:STK_LO] | $past(stat_o[STK_HI:STK_LO])) == stat_o[STK_HI:STK_LO]));

  // R4
  summary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(stat_o[SUM_B]));

  // R8
  enabled_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && fac_en && inv_en && (snan_i || imz_i || isi_i)
    |=> !wr_en_o && !stat_o[FR_B] && !stat_o[FI_B]);

  // R6
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && fac_en && !(inv_en && (snan_i || imz_i || isi_i))
    |=> wr_en_o && (wr_hi_o == $past(res64_i)));

  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_lo_o == '0));
endmodule

bind fpx_commit fpx_commit_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .op_valid (op_valid),
  .fac_en   (fac_en),
  .inv_en   (inv_en),
  .snan_i   (snan_i),
  .imz_i    (imz_i),
  .isi_i    (isi_i),
  .res64_i  (res64_i),
  .wr_en_o  (wr_en_o),
  .wr_hi_o  (wr_hi_o),
  .wr_lo_o  (wr_lo_o),
  .stat_o   (stat_o),
  .trap_o   (trap_o)
);

// File: tb/sim_fpx_commit.sv
module sim_fpx_commit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, fac_en, inv_en;
  logic        snan_i, imz_i, isi_i, ovf_i, unf_i, inx_i, rinc_i;
  logic [31:0] res32_i;
  logic [63:0] res64_i;
  logic        wr_en_o, trap_o;
  logic [63:0] wr_hi_o, wr_lo_o;
  logic [13:0] stat_o;

  int checks = 0;
  int failures = 0;
  logic [13:0] e_stat;

  always #(PERIOD/2) clk = ~clk;

  fpx_commit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fac_en(fac_en), .inv_en(inv_en),
    .snan_i(snan_i), .imz_i(imz_i), .isi_i(isi_i), .ovf_i(ovf_i), .unf_i(unf_i),
    .inx_i(inx_i), .rinc_i(rinc_i), .res32_i(res32_i), .res64_i(res64_i),
    .wr_en_o(wr_en_o), .wr_hi_o(wr_hi_o), .wr_lo_o(wr_lo_o), .stat_o(stat_o), .trap_o(trap_o)
  );

  function automatic logic [4:0] ref_cls(input logic [31:0] v);
    logic       s;
    logic [7:0] e;
    logic [22:0] f;
    s = v[31];
    e = v[30:23];
    f = v[22:0];
    if (e == 8'hFF) return (f != 0) ? 5'b10001 : (s ? 5'b01001 : 5'b00101);
    if (e == 8'h00) begin
      if (f == 0) return s ? 5'b10010 : 5'b00010;
      return s ? 5'b11000 : 5'b10100;
    end
    return s ? 5'b01000 : 5'b00100;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; fac_en = 1; inv_en = 0;
    snan_i = 0; imz_i = 0; isi_i = 0; ovf_i = 0; unf_i = 0; inx_i = 0; rinc_i = 0;
    res32_i = '0; res64_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk(stat_o == 0, "R1", "stat in reset", 64'(stat_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    e_stat = '0;
    chk(stat_o == 0 && !wr_en_o && !trap_o, "R1", "after reset",
        {48'd0, wr_en_o, trap_o, stat_o}, 0);
  endtask

  // drive one operation at a falling edge, check at the next falling edge
  task automatic do_op(input bit fe, input bit ie, input bit sn, input bit iz, input bit ii,
                       input bit ov, input bit un, input bit ix, input bit ri,
                       input logic [31:0] r32, input logic [63:0] r64, input string tag);
    bit vex, e_wr, e_trap;
    logic [5:0] raise;
    op_valid = 1; fac_en = fe; inv_en = ie;
    snan_i = sn; imz_i = iz; isi_i = ii; ovf_i = ov; unf_i = un; inx_i = ix; rinc_i = ri;
    res32_i = r32; res64_i = r64;
    e_trap = !fe;
    e_wr   = 0;
    if (fe) begin
      vex   = ie && (sn || iz || ii);                 // R5
      raise = {ix, un, ov, ii, iz, sn};
      if ((raise & ~e_stat[6:1]) != 0) e_stat[0] = 1'b1; // R4
      e_stat[6:1] = e_stat[6:1] | raise;                  // R3
      if (vex) begin
        e_stat[7] = 0; e_stat[8] = 0;                     // R8
      end else begin
        e_wr = 1;
        e_stat[7] = ri; e_stat[8] = ix;                   // R7
        e_stat[13:9] = ref_cls(r32);                      // R9
      end
    end
    @(negedge clk);
    idle_inputs();
    chk(trap_o == e_trap, "R2", {tag, " trap"}, 64'(trap_o), 64'(e_trap));
    chk(wr_en_o == e_wr, "R8", {tag, " wr_en"}, 64'(wr_en_o), 64'(e_wr));
    chk(stat_o == e_stat, "R7", {tag, " stat"}, 64'(stat_o), 64'(e_stat));
    if (e_wr) begin
      chk(wr_hi_o == r64, "R6", {tag, " hi"}, wr_hi_o, r64);
      chk(wr_lo_o == 0, "R6", {tag, " lo"}, wr_lo_o, 0);
    end
  endtask

  function automatic logic [31:0] pick32();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 6)
      0: v[30:23] = 8'hFF;
      1: v[30:23] = 8'h00;
      2: v[30:0] = 31'd0;
      3: begin v[30:23] = 8'hFF; v[22:0] = 0; end
      default: ;
    endcase
    return v;
  endfunction

  initial begin : watchdog
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    rst_n = 0;
    idle_inputs();
    e_stat = '0;
    do_reset();

    // R9: each class code, no indicators, so the summary must stay 0 (R4)
    do_op(1,0,0,0,0,0,0,0,0, 32'h0000_0000, 64'h1, "R9 +zero");
    do_op(1,0,0,0,0,0,0,0,0, 32'h8000_0000, 64'h2, "R9 -zero");
    do_op(1,0,0,0,0,0,0,0,0, 32'h7F80_0000, 64'h3, "R9 +inf");
    do_op(1,0,0,0,0,0,0,0,0, 32'hFF80_0000, 64'h4, "R9 -inf");
    do_op(1,0,0,0,0,0,0,0,1, 32'h7FC0_0001, 64'h5, "R9 nan");
    do_op(1,0,0,0,0,0,0,0,0, 32'h0000_0010, 64'h6, "R9 +den");
    do_op(1,0,0,0,0,0,0,0,0, 32'h8040_0000, 64'h7, "R9 -den");
    do_op(1,0,0,0,0,0,0,0,0, 32'h3F80_0000, 64'h8, "R9 +norm");
    do_op(1,0,0,0,0,0,0,0,0, 32'hC120_0000, 64'h9, "R9 -norm");
    chk(stat_o[0] == 0, "R4", "summary quiet without raise", 64'(stat_o[0]), 0);

    // R3: idle cycle with indicators high changes nothing
    @(negedge clk);
    snan_i = 1; ovf_i = 1; inx_i = 1; rinc_i = 1;
    @(negedge clk);
    chk(stat_o == e_stat && !wr_en_o, "R3", "idle ignored",
        {49'd0, wr_en_o, stat_o}, {50'd0, e_stat});
    idle_inputs();

    // R2: facility disabled with indicators high
    do_op(0,1,1,1,1,1,1,1,1, 32'h3F80_0000, 64'hDEAD, "R2 disabled");

    // R3/R4: single indicators each on its own bit
    do_op(1,0,0,0,0,1,0,0,0, 32'h7F80_0000, 64'hA1, "R3 ovf");
    do_op(1,0,0,0,0,0,1,1,1, 32'h0000_0001, 64'hA2, "R3 unf inx");
    do_op(1,0,0,0,0,1,0,1,0, 32'h3F80_0000, 64'hA3, "R4 re-raise");

    // R5/R8: every invalid combination with the enable clear and set
    for (int ie = 0; ie < 2; ie++) begin
      for (int c = 0; c < 8; c++) begin
        do_reset();
        do_op(1, 1'(ie), 1'(c), 1'(c >> 1), 1'(c >> 2), 0, 0, 1, 1,
              32'h4000_0000, 64'hC0DE_0000 + 64'(c), "R5 combo");
        // a clean follow-up shows the class was kept or replaced as required
        do_op(1, 1'(ie), 0, 0, 0, 0, 0, 0, 0, 32'hFF80_0000, 64'hBEEF, "R8 follow");
      end
    end

    // random mix
    for (int r = 0; r < 30; r++) begin
      do_reset();
      for (int k = 0; k < 20; k++) begin
        do_op(($urandom % 8) != 0, $urandom % 2,
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
              $urandom % 2, pick32(), {$urandom, $urandom}, "R7 random");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule